// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer that sits between two unrelated clock domains. A producer pushes words on the write clock and a consumer pulls them on the read clock. The two clocks may run at any ratio; neither is assumed to be the faster one. Write and read pointers cross between the domains as Gray code through a chain of synchronizer flops. Each side works out its own flags from its own pointer and the synchronized copy of the other pointer. The storage depth is a power-of-two parameter, so a simulation can use a small buffer.

Each side has one dual-purpose flag whose meaning depends on a timing mode. The mode is captured during master reset. In standard mode the read flag means "empty", the write flag means "full", and a read request is needed to move a word onto the output. In fall-through mode the read flag means "output holds a valid word" and the write flag means "room for a word". The oldest word then reaches the output with no request. The block also gives a half-full flag and two level flags, almost-empty and almost-full, whose thresholds can be programmed. Both thresholds come up at one of two preset values, chosen at master reset. Software can rewrite them from the data bus or shift them in one bit at a time. A partial reset empties the buffer but keeps the thresholds. A retransmit pulse rewinds reading to the first word stored since the last reset.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words come out in the order they went in, all 18 bits intact, whatever the ratio and phase of the two clocks.
- R2: In standard mode (captured mode input 0), `rd_flag` is 1 while no word is readable. A read request at a read-clock edge with a word available puts that word on `dout` at the same edge.
- R3: In fall-through mode (captured mode input 1), `rd_flag` is 1 while `dout` holds a valid word. The first word written into an empty buffer reaches `dout` with no read request. `dout` keeps its value until a read request consumes it.
- R4: In standard mode, `wr_flag` is 1 when DEPTH words are stored. In fall-through mode, `wr_flag` is 1 while a write will be accepted; the word on the output stage adds one place, for a total of DEPTH+1.
- R5: A write while the buffer is full is dropped, and a read while it is empty leaves `dout` and the pointers unchanged.
- R6: `hf_flag` is 1 while the count seen on the write side is greater than DEPTH/2.
- R7: `af_flag` is 1 while free places (DEPTH minus stored count) are at most the almost-full threshold. `ae_flag` is 1 while the readable count is at most the almost-empty threshold.
- R8: Master reset empties the buffer and captures `mode_si` as the timing mode (0 standard, 1 fall-through). It also sets both thresholds to max(1, DEPTH/64-1) when `off_sel` is 0, or to DEPTH/8-1 when `off_sel` is 1.
- R9: Partial reset empties the buffer and keeps both programmed thresholds and the timing mode.
- R10: With `ld` and `wr_en` both 1 at a write edge, `din[AW-1:0]` (AW = log2 DEPTH) is loaded into a threshold instead of being stored. Loads alternate: almost-empty first, then almost-full. Either reset returns the sequence to almost-empty.
- R11: With `ser_en` at 1, each write edge shifts `mode_si` into a 2*AW-bit threshold chain and stores no data. After 2*AW edges, the first bit shifted is bit 0 of the almost-empty threshold, and bit AW of the sequence is bit 0 of the almost-full threshold.
- R12: A one-cycle `rt` pulse moves reading back to the first word written since the last reset, provided fewer than DEPTH words were written since then. Later reads return the words again in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high, held for several edges of both clocks |
| prst | input | 1 | Partial reset, synchronous, active high, held for several edges of both clocks |
| mode_si | input | 1 | Timing mode captured at master reset; serial threshold bit otherwise |
| off_sel | input | 1 | Preset threshold choice captured at master reset |
| wr_en | input | 1 | Write request |
| ld | input | 1 | Parallel threshold load strobe, qualified by wr_en |
| ser_en | input | 1 | Serial threshold shift enable |
| din | input | 18 | Write data |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit pulse, read clock |
| dout | output | 18 | Read data |
| rd_flag | output | 1 | Empty (standard) or output valid (fall-through) |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| hf_flag | output | 1 | More than half full |
| ae_flag | output | 1 | Almost empty |
| af_flag | output | 1 | Almost full |

## Verification
Assertions check four things on every cycle. A refused write or read leaves the pointers still, and the write-side Gray pointer never changes more than one bit per edge. A valid fall-through word holds until it is read, and retransmit rewinds the read pointer. The thresholds take the preset after master reset and survive partial reset. Other behaviour can only be shown by the bench's scenarios. These are data order across unrelated clock phases, the exact fill counts at which each level flag switches, and whether parallel and serial loads put bits into the right threshold. They also include the first-word latency in fall-through mode and the data replayed after a retransmit.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    localparam int unsigned WORD_W = 18;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } tmode_e;

    // Smaller threshold preset: one 64th of the depth minus one, never below one.
    function automatic int unsigned preset_small(input int unsigned depth);
        return (depth / 64 > 1) ? (depth / 64 - 1) : 1;
    endfunction

    // Larger threshold preset: one eighth of the depth minus one.
    function automatic int unsigned preset_large(input int unsigned depth);
        return depth / 8 - 1;
    endfunction

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar s = 0; s < STAGES; s++) begin : g_st
        logic [W-1:0] r;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (clr) r <= '0;
                else     r <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (clr) r <= '0;
                else     r <= g_st[s-1].r;
            end
        end
    end

    assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int PW    = 7
) (
    input  logic          clk,
    input  logic          rst_m,
    input  logic          rst_p,
    input  logic          mode_in,
    input  logic          sel_in,
    input  logic          wr_en,
    input  logic          ld,
    input  logic          ser_en,
    input  logic [AW-1:0] ld_val,
    input  logic [PW-1:0] rgray_s,
    output logic [AW-1:0] wr_addr,
    output logic          wr_do,
    output logic          wr_flag,
    output logic          af_flag,
    output logic          hf_flag,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off,
    output logic [PW-1:0] wgray
);

    localparam logic [PW-1:0] ONE    = PW'(1);
    localparam logic [PW-1:0] FULLC  = PW'(DEPTH);
    localparam logic [PW-1:0] HALF   = PW'(DEPTH / 2);
    localparam logic [AW-1:0] OFF_LO = AW'(preset_small(DEPTH));
    localparam logic [AW-1:0] OFF_HI = AW'(preset_large(DEPTH));

    tmode_e        mode_r;
    logic          clr;
    logic          full;
    logic          ld_sel;
    logic [PW-1:0] wptr;
    logic [PW-1:0] rbin;
    logic [PW-1:0] used;
    logic [PW-1:0] free;

    assign clr = rst_m | rst_p;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
    end

    assign used    = wptr - rbin;
    assign free    = FULLC - used;
    assign full    = (used == FULLC);
    assign wr_do   = wr_en & ~ld & ~ser_en & ~full & ~clr;
    assign wr_addr = wptr[AW-1:0];
    assign wr_flag = (mode_r == MODE_FALL) ? ~full : full;
    assign af_flag = (free <= {1'b0, af_off});
    assign hf_flag = (used > HALF);

    always_ff @(posedge clk) begin
        if (clr) begin
            wptr   <= '0;
            wgray  <= '0;
            ld_sel <= 1'b0;
            if (rst_m) begin
                mode_r <= tmode_e'(mode_in);
                ae_off <= sel_in ? OFF_HI : OFF_LO;
                af_off <= sel_in ? OFF_HI : OFF_LO;
            end
        end else begin
            if (wr_do) wptr <= wptr + ONE;
            wgray <= wptr ^ (wptr >> 1);
            if (ser_en) begin
                {af_off, ae_off} <= {mode_in, af_off, ae_off[AW-1:1]};
            end else if (ld && wr_en) begin
                if (!ld_sel) ae_off <= ld_val;
                else         af_off <= ld_val;
                ld_sel <= ~ld_sel;
            end
        end
    end

    a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (clr)
        (full && wr_en) |=> $stable(wptr));

    a_r1_gray_single_step: assert property (@(posedge clk) disable iff (clr)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

    a_r6_full_implies_half: assert property (@(posedge clk) disable iff (clr)
        full |-> hf_flag);

    a_r8_preset_after_master: assert property (@(posedge clk)
        rst_m |=> (ae_off == ($past(sel_in) ? OFF_HI : OFF_LO)) &&
                  (af_off == ($past(sel_in) ? OFF_HI : OFF_LO)));

    a_r9_partial_keeps_offsets: assert property (@(posedge clk)
        (rst_p && !rst_m) |=> $stable(ae_off) && $stable(af_off));

endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int PW    = 7
) (
    input  logic          clk,
    input  logic          rst_m,
    input  logic          rst_p,
    input  logic          mode_in,
    input  logic          rd_en,
    input  logic          rt,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] ae_off,
    input  word_t         mem_q,
    output logic [AW-1:0] rd_addr,
    output word_t         dout,
    output logic          rd_flag,
    output logic          ae_flag,
    output logic [PW-1:0] rgray
);

    localparam logic [PW-1:0] ONE = PW'(1);

    tmode_e        mode_r;
    logic          clr;
    logic          valid;
    logic          ram_ne;
    logic          fetch;
    logic [PW-1:0] rptr;
    logic [PW-1:0] wbin;
    logic [PW-1:0] avail;
    logic [PW-1:0] level;

    assign clr = rst_m | rst_p;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
    end

    assign avail   = wbin - rptr;
    assign ram_ne  = (avail != '0);
    assign fetch   = (mode_r == MODE_FALL) ? (ram_ne & (~valid | rd_en))
                                           : (ram_ne & rd_en);
    assign level   = avail + {{(PW-1){1'b0}}, valid};
    assign rd_flag = (mode_r == MODE_FALL) ? valid : ~ram_ne;
    assign ae_flag = (level <= {1'b0, ae_off});
    assign rd_addr = rptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (clr) begin
            rptr  <= '0;
            rgray <= '0;
            valid <= 1'b0;
            dout  <= '0;
            if (rst_m) mode_r <= tmode_e'(mode_in);
        end else begin
            rgray <= rptr ^ (rptr >> 1);
            if (rt) begin
                rptr  <= '0;
                valid <= 1'b0;
            end else begin
                if (fetch) begin
                    rptr <= rptr + ONE;
                    dout <= mem_q;
                end
                if (mode_r == MODE_FALL) valid <= fetch | (valid & ~rd_en);
            end
        end
    end

    a_r5_no_read_when_empty: assert property (@(posedge clk) disable iff (clr)
        (mode_r == MODE_STD && !ram_ne && rd_en && !rt) |=> $stable(rptr) && $stable(dout));

    a_r3_hold_until_read: assert property (@(posedge clk) disable iff (clr)
        (mode_r == MODE_FALL && valid && !rd_en && !rt) |=> valid && $stable(dout));

    a_r12_rewind: assert property (@(posedge clk) disable iff (clr)
        rt |=> (rptr == '0));

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import fifo_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        mrst,
    input  logic        prst,
    input  logic        mode_si,
    input  logic        off_sel,
    input  logic        wr_en,
    input  logic        ld,
    input  logic        ser_en,
    input  logic [17:0] din,
    input  logic        rd_en,
    input  logic        rt,
    output logic [17:0] dout,
    output logic        rd_flag,
    output logic        wr_flag,
    output logic        hf_flag,
    output logic        ae_flag,
    output logic        af_flag
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    word_t         mem [DEPTH];
    word_t         mem_q;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          wr_do;
    logic [AW-1:0] ae_off;
    logic [AW-1:0] af_off;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray_s;

    always_ff @(posedge wclk) begin
        if (wr_do) mem[wr_addr] <= din;
    end

    assign mem_q = mem[rd_addr];

    fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk (rclk),
        .clr (mrst | prst),
        .d   (wgray),
        .q   (wgray_s)
    );

    fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk (wclk),
        .clr (mrst | prst),
        .d   (rgray),
        .q   (rgray_s)
    );

    fifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk     (wclk),
        .rst_m   (mrst),
        .rst_p   (prst),
        .mode_in (mode_si),
        .sel_in  (off_sel),
        .wr_en   (wr_en),
        .ld      (ld),
        .ser_en  (ser_en),
        .ld_val  (din[AW-1:0]),
        .rgray_s (rgray_s),
        .wr_addr (wr_addr),
        .wr_do   (wr_do),
        .wr_flag (wr_flag),
        .af_flag (af_flag),
        .hf_flag (hf_flag),
        .ae_off  (ae_off),
        .af_off  (af_off),
        .wgray   (wgray)
    );

    fifo_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .clk     (rclk),
        .rst_m   (mrst),
        .rst_p   (prst),
        .mode_in (mode_si),
        .rd_en   (rd_en),
        .rt      (rt),
        .wgray_s (wgray_s),
        .ae_off  (ae_off),
        .mem_q   (mem_q),
        .rd_addr (rd_addr),
        .dout    (dout),
        .rd_flag (rd_flag),
        .ae_flag (ae_flag),
        .rgray   (rgray)
    );

endmodule

// File: tb/tb_dcfifo_pflag.sv
`timescale 1ns/1ps
module tb_dcfifo_pflag;

    localparam int DEPTH = 64;
    localparam int NRND  = 400;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        mrst, prst, mode_si, off_sel, wr_en, ld, ser_en, rd_en, rt;
    logic [17:0] din;
    logic [17:0] dout;
    logic        rd_flag, wr_flag, hf_flag, ae_flag, af_flag;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [17:0] model[$];
    logic [17:0] v;
    int unsigned seed_val;

    always #4    wclk = ~wclk;
    always #5.5  rclk = ~rclk;

    dcfifo_pflag #(.DEPTH(DEPTH)) dut (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .mode_si(mode_si),
        .off_sel(off_sel), .wr_en(wr_en), .ld(ld), .ser_en(ser_en), .din(din),
        .rd_en(rd_en), .rt(rt), .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag),
        .hf_flag(hf_flag), .ae_flag(ae_flag), .af_flag(af_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (2) @(negedge wclk);
    endtask

    task automatic do_reset(input logic m, input logic p, input logic md, input logic s);
        @(negedge wclk);
        mrst = m; prst = p; mode_si = md; off_sel = s;
        repeat (5) @(negedge rclk);
        mrst = 1'b0; prst = 1'b0; mode_si = 1'b0;
        settle();
    endtask

    task automatic wr1(input logic [17:0] d);
        @(negedge wclk);
        din = d; wr_en = 1'b1;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic rd_std(output logic [17:0] d);
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        d = dout;
    endtask

    task automatic rd_fall(output logic [17:0] d);
        @(negedge rclk);
        while (!rd_flag) @(negedge rclk);
        d = dout;
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Random traffic in one mode; expected data from the queue model
    task automatic random_run(input logic fall);
        do_reset(1'b1, 1'b0, fall, 1'b0);
        fork
            begin : writer
                int i = 0;
                while (i < NRND) begin
                    @(negedge wclk);
                    if (($urandom % 4 != 0) && (fall ? wr_flag : !wr_flag)) begin
                        din = 18'($urandom);
                        wr_en = 1'b1;
                        model.push_back(din);
                        i++;
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin : reader
                int  got  = 0;
                logic pend = 1'b0;
                while (got < NRND) begin
                    @(negedge rclk);
                    if (!fall) begin
                        if (pend) begin
                            chk("R1 R2 random standard order", dout, model.pop_front());
                            got++;
                        end
                        rd_en = !rd_flag && ($urandom % 3 != 0);
                        pend  = rd_en;
                    end else begin
                        rd_en = 1'b0;
                        if (rd_flag) begin
                            chk("R1 R3 random fall-through order", dout, model[0]);
                            if ($urandom % 3 != 0) begin
                                rd_en = 1'b1;
                                void'(model.pop_front());
                                got++;
                            end
                        end
                    end
                end
                @(negedge rclk);
                rd_en = 1'b0;
            end
        join
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge wclk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        summary();
        $finish;
    end

    initial begin : main
        mrst = 1'b1; prst = 1'b0; mode_si = 1'b0; off_sel = 1'b0;
        wr_en = 1'b0; ld = 1'b0; ser_en = 1'b0; rd_en = 1'b0; rt = 1'b0; din = '0;
        seed_val = $urandom(32'd20417);
        repeat (5) @(negedge rclk);
        mrst = 1'b0;
        settle();

        // R8: reset state in standard mode, small preset (1)
        chk("R8 reset rd_flag empty", rd_flag, 1);
        chk("R8 reset wr_flag", wr_flag, 0);
        chk("R8 reset hf_flag", hf_flag, 0);
        chk("R8 reset af_flag", af_flag, 0);
        chk("R8 reset ae_flag", ae_flag, 1);

        // Fill to full: R7 thresholds, R6 half, R4 full
        for (int k = 1; k <= DEPTH; k++) begin
            wr1(18'h2A000 + 18'(k - 1));
            if (k == 1)  begin settle(); chk("R7 R8 ae at level 1 (offset 1)", ae_flag, 1); end
            if (k == 2)  begin settle(); chk("R7 ae drops at level 2", ae_flag, 0); end
            if (k == 32) chk("R6 hf at 32", hf_flag, 0);
            if (k == 33) chk("R6 hf at 33", hf_flag, 1);
            if (k == 62) chk("R7 af at 62", af_flag, 0);
            if (k == 63) begin chk("R7 af at 63", af_flag, 1); chk("R4 not full at 63", wr_flag, 0); end
            if (k == 64) chk("R4 full at 64", wr_flag, 1);
        end
        wr1(18'h3FFFF); // R5: dropped
        for (int k = 0; k < DEPTH; k++) begin
            rd_std(v);
            chk("R2 R5 standard read order", v, 18'h2A000 + 18'(k));
        end
        settle();
        chk("R2 empty after draining", rd_flag, 1);
        rd_std(v);
        chk("R5 read when empty keeps dout", v, 18'h2A03F);

        // R10: parallel load ae=5, af=10
        @(negedge wclk); ld = 1'b1; wr_en = 1'b1; din = 18'd5;
        @(negedge wclk); din = 18'd10;
        @(negedge wclk); ld = 1'b0; wr_en = 1'b0;
        settle();
        chk("R10 load stores no data", rd_flag, 1);
        for (int k = 1; k <= 54; k++) begin
            wr1(18'h1000 + 18'(k));
            if (k == 5)  begin settle(); chk("R10 ae offset 5 at level 5", ae_flag, 1); end
            if (k == 6)  begin settle(); chk("R10 ae offset 5 at level 6", ae_flag, 0); end
            if (k == 53) chk("R10 af offset 10 at 53", af_flag, 0);
            if (k == 54) chk("R10 af offset 10 at 54", af_flag, 1);
        end

        // R9: partial reset keeps offsets 5/10
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 empty after partial reset", rd_flag, 1);
        chk("R9 hf cleared", hf_flag, 0);
        for (int k = 1; k <= 6; k++) begin
            wr1(18'h0500 + 18'(k));
            if (k == 5) begin settle(); chk("R9 ae offset kept at 5", ae_flag, 1); end
            if (k == 6) begin settle(); chk("R9 ae offset kept at 6", ae_flag, 0); end
        end

        // R11: serial load ae=3, af=20, almost-empty bits first, LSB first
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        begin
            logic [11:0] word = {6'd20, 6'd3};
            for (int i = 0; i < 12; i++) begin
                @(negedge wclk); ser_en = 1'b1; mode_si = word[i];
            end
            @(negedge wclk); ser_en = 1'b0; mode_si = 1'b0;
        end
        settle();
        chk("R11 serial shift stores no data", rd_flag, 1);
        for (int k = 1; k <= 44; k++) begin
            wr1(18'h0700 + 18'(k));
            if (k == 3)  begin settle(); chk("R11 ae offset 3 at 3", ae_flag, 1); end
            if (k == 4)  begin settle(); chk("R11 ae offset 3 at 4", ae_flag, 0); end
            if (k == 43) chk("R11 af offset 20 at 43", af_flag, 0);
            if (k == 44) chk("R11 af offset 20 at 44", af_flag, 1);
        end

        // R8: master reset with large preset (7)
        do_reset(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R8 master reset empties", rd_flag, 1);
        for (int k = 1; k <= 57; k++) begin
            wr1(18'h0900 + 18'(k));
            if (k == 7)  begin settle(); chk("R8 large preset ae at 7", ae_flag, 1); end
            if (k == 8)  begin settle(); chk("R8 large preset ae at 8", ae_flag, 0); end
            if (k == 56) chk("R8 large preset af at 56", af_flag, 0);
            if (k == 57) chk("R8 large preset af at 57", af_flag, 1);
        end

        // R12: retransmit
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 10; k++) wr1(18'h0100 + 18'(k));
        settle();
        for (int k = 0; k < 4; k++) begin
            rd_std(v);
            chk("R12 reads before rewind", v, 18'h0100 + 18'(k));
        end
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk); rt = 1'b0;
        settle();
        for (int k = 0; k < 10; k++) begin
            rd_std(v);
            chk("R12 replay after rewind", v, 18'h0100 + 18'(k));
        end
        settle();
        chk("R12 empty after replay", rd_flag, 1);

        // R3/R4: fall-through mode
        do_reset(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R4 fall-through input ready at reset", wr_flag, 1);
        chk("R3 no valid output at reset", rd_flag, 0);
        wr1(18'h01234);
        settle();
        chk("R3 first word valid without read", rd_flag, 1);
        chk("R3 first word on dout", dout, 18'h01234);
        for (int k = 0; k < DEPTH; k++) wr1(18'h2000 + 18'(k));
        settle();
        chk("R4 not ready at DEPTH+1", wr_flag, 0);
        wr1(18'h3FFFF); // R5: dropped
        rd_fall(v);
        chk("R3 fall-through first read", v, 18'h01234);
        for (int k = 0; k < DEPTH; k++) begin
            rd_fall(v);
            chk("R3 R5 fall-through order", v, 18'h2000 + 18'(k));
        end
        settle();
        chk("R5 fall-through dropped write absent", rd_flag, 0);

        // R1: random traffic in both modes
        random_run(1'b0);
        random_run(1'b1);

        summary();
        $finish;
    end

endmodule